// File: doc/BRIEF.md
# DMA Channel Event Flag Bank

This block collects the completion and error events of eight DMA channels into sticky flags. Software reads the flags through a small register port and clears them by writing ones. Each channel raises a pulse on any of five event inputs: FIFO error, single-data error, transfer error, half-transfer done and full-transfer done. The pulse sets the matching flag, and the flag stays set until it is cleared.

The channels are split into two halves. Channels 0 to 3 report in one 32-bit flag word and channels 4 to 7 in a second word. Each flag word has a write-one-to-clear partner word. Enable words use the same bit layout as the flag words. A channel's interrupt output is high while any of its flags is set together with the enable at the same position.

The transfer engines and the system interrupt controller are outside this block.

Top module: `dma_flag_bank`

## Requirements
- R1: Channel c reports in flag word c/4. Word 0 is at address 0 and word 1 at address 1. The channel's 6-bit group starts at bit 8k-2(k mod 2), where k = c mod 4, giving offsets 0, 6, 16 and 22. Within a group the bits are: bit 0 FIFO error, bit 1 unused, bit 2 single-data error, bit 3 transfer error, bit 4 half-transfer, bit 5 full-transfer.
- R2: An event pulse sets its flag, which reads as 1 from the clock edge that samples the pulse onward. The flag holds until it is cleared.
- R3: A write to address 2 (channels 0-3) or address 3 (channels 4-7) clears each flag whose position is written with 1. Flags at positions written with 0 are unchanged.
- R4: When an event pulse and a clear of the same flag fall in the same cycle, the flag ends up set.
- R5: Unused bit positions in the flag and enable words read as 0. These are bit 1 of each group and bits 12-15 and 28-31.
- R6: Writes to addresses 0 and 1 change nothing. Addresses 2, 3, 6 and 7 read as 0.
- R7: The enable words are at address 4 (channels 0-3) and address 5 (channels 4-7). They use the same group layout as the flag words, are written and read back there, and writes to their unused positions are dropped.
- R8: irq[c] is high exactly when some flag of channel c is set and its enable, at the same group bit, is set. Bit 0 of the group is the FIFO error enable.
- R9: After synchronous reset, all flags and enables are 0 and every irq output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_fifo_err | input | 8 | Per-channel FIFO error pulse |
| ev_sdata_err | input | 8 | Per-channel single-data error pulse |
| ev_xfer_err | input | 8 | Per-channel transfer error pulse |
| ev_half | input | 8 | Per-channel half-transfer pulse |
| ev_full | input | 8 | Per-channel full-transfer pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 8 | Per-channel interrupt line |

## Verification
A wrong flag or enable bit becomes visible at the ports on the first read of its word after the clock edge that stored it. For an enabled flag it also shows at once on the channel's irq line. A group placed at the wrong offset, or in the wrong half, moves bits to other positions in the read word, so a read of both words after events on every channel exposes it. A dropped clear, a clear that wins over a set, or a write that leaks into the flag words shows as a mismatch against the model on the next cycle. The bench compares both words, both enable words and all irq lines every cycle.

// File: rtl/dma_flag_pkg.sv
package dma_flag_pkg;
    localparam int GRP_W       = 6;
    localparam int CH_PER_WORD = 4;
    localparam int WORD_W      = 32;

    // bit positions inside a channel group (neighbours decode these)
    localparam int B_FIFO  = 0;
    localparam int B_SDATA = 2;
    localparam int B_XFER  = 3;
    localparam int B_HALF  = 4;
    localparam int B_FULL  = 5;
    localparam logic [GRP_W-1:0] GRP_USED = 6'b111101;

    localparam logic [2:0] ADDR_FLAG_BASE = 3'd0;
    localparam logic [2:0] ADDR_CLR_BASE  = 3'd2;
    localparam logic [2:0] ADDR_EN_BASE   = 3'd4;

    typedef struct packed {
        logic full;
        logic half;
        logic xfer;
        logic sdata;
        logic fifo;
    } evt_t;

    function automatic int grp_off(input int k);
        return 8 * k - 2 * (k % 2);
    endfunction

    function automatic logic [GRP_W-1:0] evt_to_grp(input evt_t e);
        logic [GRP_W-1:0] g;
        g          = '0;
        g[B_FIFO]  = e.fifo;
        g[B_SDATA] = e.sdata;
        g[B_XFER]  = e.xfer;
        g[B_HALF]  = e.half;
        g[B_FULL]  = e.full;
        return g;
    endfunction

    function automatic logic [WORD_W-1:0] word_used_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int k = 0; k < CH_PER_WORD; k++)
            m[grp_off(k) +: GRP_W] = GRP_USED;
        return m;
    endfunction
endpackage

// File: rtl/dma_flag_chan.sv
module dma_flag_chan
    import dma_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt,
    input  logic [GRP_W-1:0] clr_mask,
    input  logic             en_we,
    input  logic [GRP_W-1:0] en_wdata,
    output logic [GRP_W-1:0] flags,
    output logic [GRP_W-1:0] ens,
    output logic             irq
);
    logic [GRP_W-1:0] set_vec;

    assign set_vec = evt_to_grp(evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            ens   <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | set_vec;
            if (en_we)
                ens <= en_wdata & GRP_USED;
        end
    end

    assign irq = |(flags & ens);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R4

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|(clr_mask & ~set_vec)) |=> ((flags & $past(clr_mask & ~set_vec)) == '0)); // R3

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (clr_mask == '0 && set_vec == '0) |=> $stable(flags)); // R2
endmodule

// File: rtl/dma_flag_pack.sv
module dma_flag_pack
    import dma_flag_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int NUM_WORDS = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD
) (
    input  logic [NUM_CH-1:0][GRP_W-1:0]     grp,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] words
);
    always_comb begin
        words = '0;
        for (int c = 0; c < NUM_CH; c++)
            words[c / CH_PER_WORD][grp_off(c % CH_PER_WORD) +: GRP_W] = grp[c];
    end
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank
    import dma_flag_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ev_fifo_err,
    input  logic [NUM_CH-1:0] ev_sdata_err,
    input  logic [NUM_CH-1:0] ev_xfer_err,
    input  logic [NUM_CH-1:0] ev_half,
    input  logic [NUM_CH-1:0] ev_full,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic [NUM_CH-1:0] irq
);
    localparam int NUM_WORDS = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD;
    localparam logic [WORD_W-1:0] USED_WORD = word_used_mask();

    logic [NUM_CH-1:0][GRP_W-1:0]     flag_grp;
    logic [NUM_CH-1:0][GRP_W-1:0]     en_grp;
    logic [NUM_WORDS-1:0][WORD_W-1:0] flag_words;
    logic [NUM_WORDS-1:0][WORD_W-1:0] en_words;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int         W        = c / CH_PER_WORD;
        localparam int         OFF      = grp_off(c % CH_PER_WORD);
        localparam logic [2:0] CLR_ADDR = ADDR_CLR_BASE + 3'(W);
        localparam logic [2:0] EN_ADDR  = ADDR_EN_BASE + 3'(W);

        evt_t             evt;
        logic [GRP_W-1:0] clr_mask;
        logic             en_we;

        assign evt.fifo  = ev_fifo_err[c];
        assign evt.sdata = ev_sdata_err[c];
        assign evt.xfer  = ev_xfer_err[c];
        assign evt.half  = ev_half[c];
        assign evt.full  = ev_full[c];

        assign clr_mask = (wr_en && wr_addr == CLR_ADDR) ? wr_data[OFF +: GRP_W] : '0;
        assign en_we    = wr_en && wr_addr == EN_ADDR;

        dma_flag_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt),
            .clr_mask (clr_mask),
            .en_we    (en_we),
            .en_wdata (wr_data[OFF +: GRP_W]),
            .flags    (flag_grp[c]),
            .ens      (en_grp[c]),
            .irq      (irq[c])
        );
    end

    dma_flag_pack #(.NUM_CH(NUM_CH), .NUM_WORDS(NUM_WORDS)) u_pack_flag (
        .grp   (flag_grp),
        .words (flag_words)
    );

    dma_flag_pack #(.NUM_CH(NUM_CH), .NUM_WORDS(NUM_WORDS)) u_pack_en (
        .grp   (en_grp),
        .words (en_words)
    );

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_addr == ADDR_FLAG_BASE + 3'(w)) rd_data = flag_words[w];
            if (rd_addr == ADDR_EN_BASE + 3'(w))   rd_data = en_words[w];
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~USED_WORD) == '0); // R5

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_CLR_BASE || rd_addr == ADDR_CLR_BASE + 3'd1) |-> rd_data == '0); // R6
endmodule

// File: tb/tb_dma_flag_bank.sv
`timescale 1ns/1ps
module tb_dma_flag_bank;
    logic        clk = 0;
    logic        rst;
    logic [7:0]  ev_f, ev_s, ev_t, ev_h, ev_d;
    logic        wr_en;
    logic [2:0]  wr_addr, rd_addr;
    logic [31:0] wr_data, rd_data;
    logic [7:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int offs [4] = '{0, 6, 16, 22};
    logic [5:0] mf [8];
    logic [5:0] me [8];

    always #2.5 clk = ~clk;

    dma_flag_bank dut (
        .clk(clk), .rst(rst),
        .ev_fifo_err(ev_f), .ev_sdata_err(ev_s), .ev_xfer_err(ev_t),
        .ev_half(ev_h), .ev_full(ev_d),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int a);
        logic [31:0] w = '0;
        for (int c = 0; c < 8; c++) begin
            if (a == c / 4)     w[offs[c % 4] +: 6] = mf[c];
            if (a == 4 + c / 4) w[offs[c % 4] +: 6] = me[c];
        end
        return w;
    endfunction

    function automatic logic [7:0] exp_irq();
        logic [7:0] v = '0;
        for (int c = 0; c < 8; c++) v[c] = |(mf[c] & me[c]);
        return v;
    endfunction

    task automatic idle();
        ev_f = 0; ev_s = 0; ev_t = 0; ev_h = 0; ev_d = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0;
    endtask

    // inputs are already set; update model and wait for the next low phase
    task automatic tick();
        for (int c = 0; c < 8; c++) begin
            logic [5:0] set, clr;
            set = {ev_d[c], ev_h[c], ev_t[c], ev_s[c], 1'b0, ev_f[c]};
            clr = (wr_en && wr_addr == 3'(2 + c / 4)) ? wr_data[offs[c % 4] +: 6] : 6'h0;
            mf[c] = (mf[c] & ~clr) | set;
            if (wr_en && wr_addr == 3'(4 + c / 4))
                me[c] = wr_data[offs[c % 4] +: 6] & 6'h3D;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic compare_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.1;
            chk({tag, " word"}, rd_data, exp_word(a));
        end
        chk({tag, " irq R8"}, {24'h0, irq}, {24'h0, exp_irq()});
    endtask

    task automatic read_at(input int a, output logic [31:0] v);
        rd_addr = 3'(a);
        #0.1;
        v = rd_data;
    endtask

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle();
        rd_addr = 0;
        rst = 1;
        for (int c = 0; c < 8; c++) begin mf[c] = 0; me[c] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R9: reset state
        for (int a = 0; a < 8; a++) begin
            read_at(a, v);
            chk("R9 reset word", v, 32'h0);
        end
        chk("R9 reset irq", {24'h0, irq}, 32'h0);

        // R1 / R2: placement and stickiness
        ev_h[5] = 1; ev_d[2] = 1; ev_f[3] = 1;
        tick();
        read_at(1, v); chk("R1 ch5 half at bit 10", v, 32'h0000_0400);
        read_at(0, v); chk("R1 ch2 full bit 21 ch3 fifo bit 22", v, 32'h0060_0000);
        repeat (3) tick();
        read_at(0, v); chk("R2 flags held", v, 32'h0060_0000);
        ev_s[7] = 1; ev_t[4] = 1;
        tick();
        read_at(1, v); chk("R1 ch7 sdata ch4 xfer", v, 32'h0100_0408);

        // R3: write-one clear, zeros untouched
        wr_en = 1; wr_addr = 3; wr_data = 32'h0000_0400;
        tick();
        read_at(1, v); chk("R3 partial clear word1", v, 32'h0100_0008);
        read_at(0, v); chk("R3 word0 untouched", v, 32'h0060_0000);

        // R4: set wins over clear
        wr_en = 1; wr_addr = 2; wr_data = 32'h0060_0000; ev_d[2] = 1;
        tick();
        read_at(0, v); chk("R4 set wins", v, 32'h0020_0000);

        // R6: writes to flag words ignored, clear words read zero
        wr_en = 1; wr_addr = 0; wr_data = 32'hFFFF_FFFF;
        tick();
        read_at(0, v); chk("R6 flag write ignored", v, 32'h0020_0000);
        read_at(2, v); chk("R6 clear addr reads zero", v, 32'h0);
        read_at(3, v); chk("R6 clear addr reads zero", v, 32'h0);

        // R5: every event on every channel
        ev_f = 8'hFF; ev_s = 8'hFF; ev_t = 8'hFF; ev_h = 8'hFF; ev_d = 8'hFF;
        tick();
        read_at(0, v); chk("R5 full word0", v, 32'h0F7D_0F7D);
        read_at(1, v); chk("R5 full word1", v, 32'h0F7D_0F7D);

        // R7: enable write/readback drops unused bits
        wr_en = 1; wr_addr = 4; wr_data = 32'hFFFF_FFFF;
        tick();
        read_at(4, v); chk("R7 enable readback", v, 32'h0F7D_0F7D);
        read_at(5, v); chk("R7 other enable word untouched", v, 32'h0);
        chk("R8 irq all low half enabled", {24'h0, irq}, 32'h0000_000F);

        // R8: enable only ch1 half, then clear everything
        wr_en = 1; wr_addr = 4; wr_data = 32'h0000_0400;
        tick();
        wr_en = 1; wr_addr = 2; wr_data = 32'hFFFF_FFFF;
        tick();
        wr_en = 1; wr_addr = 3; wr_data = 32'hFFFF_FFFF;
        tick();
        chk("R8 irq cleared", {24'h0, irq}, 32'h0);
        ev_d[1] = 1;
        tick();
        chk("R8 non-enabled flag no irq", {24'h0, irq}, 32'h0);
        ev_h[1] = 1;
        tick();
        chk("R8 enabled half raises irq1", {24'h0, irq}, 32'h0000_0002);
        // FIFO enable at bit 0 of ch6 group
        wr_en = 1; wr_addr = 5; wr_data = 32'h0001_0000;
        tick();
        ev_f[6] = 1;
        tick();
        chk("R8 fifo enable ch6", {24'h0, irq}, 32'h0000_0042);
        compare_all("R1 directed");

        // random phase, compared every cycle against the model
        for (int i = 0; i < 3000; i++) begin
            ev_f = 8'($urandom) & 8'($urandom) & 8'($urandom);
            ev_s = 8'($urandom) & 8'($urandom) & 8'($urandom);
            ev_t = 8'($urandom) & 8'($urandom) & 8'($urandom);
            ev_h = 8'($urandom) & 8'($urandom) & 8'($urandom);
            ev_d = 8'($urandom) & 8'($urandom) & 8'($urandom);
            wr_en   = ($urandom % 3) == 0;
            wr_addr = 3'($urandom);
            wr_data = $urandom;
            tick();
            compare_all("R3 R4 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule